// File: doc/BRIEF.md
# Network Controller Run Control and Scheduling Loop

This block holds the main command and status word of a network controller and the sequencer that decides what the controller does next. A host writes the command word through a small register port. Run-control bits are set by writing ones. Event flags are cleared by writing ones. Plain enable bits take the written value. Two further registers hold the memory address of the initialization block, and they can only be written while the controller is halted.

On leaving the halted state, the sequencer does two things in order. If initialization was requested, it first clears the ring pointers held by the ring engines and then fetches the initialization block through a request/done handshake. After that, if start was requested, it enters the scheduling loop. The loop polls the receive engine, then the transmit engine, and each poll is a strobe answered by a completion pulse. When a pass sends nothing and no transmit demand is pending, the loop waits about 1.6 ms before the next pass. The interrupt line is the OR of all event flags, gated by an enable bit.

Top module: `nic_run_ctrl`

## Requirements
- R1: After reset the command word reads 0x0001, with only the halt bit (bit 0) set. `irq`, `ib_req`, `ring_reset` and both poll strobes are low.
- R2: The command word uses these bits: halt 0, init 1, start 2. A command write with bit 0 set sets halt and clears init, start and the demand bit, whatever the other bits hold. Otherwise, writing 1 to init or start sets that bit and clears halt. Writing 0 to bits 0 to 2 changes nothing.
- R3: A write with `host_sel`=1 loads address bits 15:0 and a write with `host_sel`=2 loads the address bits above 15. Both writes take effect only while halt is set and are ignored otherwise.
- R4: When halt clears with init set, the block first pulses `ring_reset` for one cycle and then holds `ib_req` high until `ib_done`. It issues no poll before that. It enters the loop only if start is set, and otherwise idles until start is written.
- R5: `ring_reset` pulses only on the initialization path. Halting and restarting with start alone leave the ring pointers untouched and raise no `ib_req`.
- R6: In the loop, each pass issues `rx_poll` (if the receive enable, bit 5, is set) and waits for `rx_poll_done`. It then issues `tx_poll` (if the transmit enable, bit 6, is set) and waits for `tx_poll_done`. Receive always comes first, and the two strobes are never high together.
- R7: If a pass sent nothing (`tx_sent` low at `tx_poll_done`) and the demand bit (bit 3) is clear, the loop pauses for CLK_HZ/625 cycles before the next pass. Otherwise the next pass starts at once, and a demand that skipped the pause is cleared.
- R8: The event flags are init-done (bit 8), receive (bit 9), transmit (bit 10), missed (bit 11) and error (bit 12). Writing 1 to a flag clears it and writing 0 leaves it unchanged. An event arriving in the same cycle as its clear leaves the flag set.
- R9: Completion of the initialization handshake sets the init-done flag.
- R10: `irq` is high exactly when the interrupt enable (bit 4) is set and any flag is set. Bit 15 of the word reads 1 whenever any flag is set.
- R11: In the cycle halt reads 1, no poll strobe, `ib_req` or `ring_reset` is driven, and the loop is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 2 | Register select: 0 command, 1 address low, 2 address high |
| host_wdata | input | 16 | Host write data |
| csr_q | output | 16 | Current command and status word |
| ib_addr | output | ADDR_W | Initialization block address |
| ring_reset | output | 1 | One-cycle pulse that resets both ring pointers |
| ib_req | output | 1 | Initialization block fetch request |
| ib_done | input | 1 | Fetch complete pulse |
| rx_poll | output | 1 | Receive poll strobe |
| rx_poll_done | input | 1 | Receive poll complete pulse |
| tx_poll | output | 1 | Transmit poll strobe |
| tx_poll_done | input | 1 | Transmit poll complete pulse |
| tx_sent | input | 1 | Qualifies tx_poll_done: a frame was sent |
| loop_active | output | 1 | Sequencer is in the scheduling loop |
| rint_evt | input | 1 | Frame received event |
| tint_evt | input | 1 | Frame transmitted event |
| miss_evt | input | 1 | Missed frame event |
| err_evt | input | 1 | Error event |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several properties on every cycle. Halt excludes init and start. The address registers stay still while running. Ring pointers are reset only when init is set. The fetch request and the polls need init and start. The strobes are mutually exclusive, and halt silences all outputs. The pause holds until its counter expires, and an arriving event always wins over its clear.

Only the bench scenarios can show the timing properties. These are the exact spacing of poll strobes under each combination of enables, send result and demand, the order of initialization before the first poll, and the fact that a restart without init keeps the ring pointers.

// File: rtl/nctl_pkg.sv
package nctl_pkg;
  localparam int B_STOP = 0;
  localparam int B_INIT = 1;
  localparam int B_STRT = 2;
  localparam int B_TDMD = 3;
  localparam int B_IE   = 4;
  localparam int B_RXEN = 5;
  localparam int B_TXEN = 6;
  localparam int B_FLG0 = 8;
  localparam int NFLAG  = 5;
  localparam int B_IRQ  = 15;

  typedef enum logic [3:0] {
    SQ_STOP, SQ_SWITCH, SQ_RCLR, SQ_IBWAIT,
    SQ_RXCHK, SQ_RXWAIT, SQ_TXCHK, SQ_TXWAIT, SQ_PAUSE
  } seq_st_t;

  // 1.6 ms = 1/625 s
  function automatic int pause_cycles(input int hz);
    int c;
    c = hz / 625;
    return (c < 1) ? 1 : c;
  endfunction
endpackage

// File: rtl/nctl_csr.sv
module nctl_csr
  import nctl_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        sel,
  input  logic [15:0]       wdata,
  input  logic              idon_evt,
  input  logic              rint_evt,
  input  logic              tint_evt,
  input  logic              miss_evt,
  input  logic              err_evt,
  input  logic              tdmd_clr,
  output logic              stop_q,
  output logic              init_q,
  output logic              strt_q,
  output logic              tdmd_q,
  output logic              ie_q,
  output logic              rxen_q,
  output logic              txen_q,
  output logic [15:0]       csr_q,
  output logic [ADDR_W-1:0] ib_addr,
  output logic              irq
);
  localparam int HI_W = ADDR_W - 16;

  logic [NFLAG-1:0] flags_q;
  logic [NFLAG-1:0] evt_vec, clr_vec;
  logic wr_cmd, wr_lo, wr_hi, go_w;

  assign wr_cmd  = wr && (sel == 2'd0);
  assign wr_lo   = wr && (sel == 2'd1) && stop_q;
  assign wr_hi   = wr && (sel == 2'd2) && stop_q;
  assign go_w    = wdata[B_INIT] || wdata[B_STRT];
  assign evt_vec = {err_evt, miss_evt, tint_evt, rint_evt, idon_evt};
  assign clr_vec = wr_cmd ? wdata[B_FLG0 +: NFLAG] : '0;

  wire unused_bits = ^{wdata[15:13], wdata[7]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_q  <= 1'b1;
      init_q  <= 1'b0;
      strt_q  <= 1'b0;
      tdmd_q  <= 1'b0;
      ie_q    <= 1'b0;
      rxen_q  <= 1'b0;
      txen_q  <= 1'b0;
      flags_q <= '0;
      ib_addr <= '0;
    end else begin
      if (wr_cmd) begin
        ie_q   <= wdata[B_IE];
        rxen_q <= wdata[B_RXEN];
        txen_q <= wdata[B_TXEN];
        if (wdata[B_STOP]) begin
          stop_q <= 1'b1;
          init_q <= 1'b0;
          strt_q <= 1'b0;
        end else if (go_w) begin
          stop_q <= 1'b0;
          if (wdata[B_INIT]) init_q <= 1'b1;
          if (wdata[B_STRT]) strt_q <= 1'b1;
        end
      end
      if (wr_cmd && wdata[B_STOP])      tdmd_q <= 1'b0;
      else if (wr_cmd && wdata[B_TDMD]) tdmd_q <= 1'b1;
      else if (tdmd_clr)                tdmd_q <= 1'b0;
      flags_q <= (flags_q & ~clr_vec) | evt_vec;
      if (wr_lo) ib_addr[15:0]       <= wdata;
      if (wr_hi) ib_addr[ADDR_W-1:16] <= wdata[HI_W-1:0];
    end
  end

  always_comb begin
    csr_q                    = '0;
    csr_q[B_STOP]            = stop_q;
    csr_q[B_INIT]            = init_q;
    csr_q[B_STRT]            = strt_q;
    csr_q[B_TDMD]            = tdmd_q;
    csr_q[B_IE]              = ie_q;
    csr_q[B_RXEN]            = rxen_q;
    csr_q[B_TXEN]            = txen_q;
    csr_q[B_FLG0 +: NFLAG]   = flags_q;
    csr_q[B_IRQ]             = |flags_q;
  end

  assign irq = ie_q && (|flags_q);

  p_stop_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> !(init_q || strt_q));
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_q |=> $stable(ib_addr));
  p_evt_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rint_evt |=> flags_q[1]);
endmodule

// File: rtl/nctl_pause.sv
module nctl_pause #(
  parameter int CYC = 80000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LOADV = CW'(CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= LOADV;
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expire = run && (cnt == '0);
endmodule

// File: rtl/nctl_seq.sv
module nctl_seq
  import nctl_pkg::*;
#(
  parameter int PAUSE_CYC = 80000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop,
  input  logic init,
  input  logic strt,
  input  logic tdmd,
  input  logic rx_en,
  input  logic tx_en,
  input  logic ib_done,
  input  logic rx_done,
  input  logic tx_done,
  input  logic tx_sent,
  output logic ring_reset,
  output logic ib_req,
  output logic rx_poll,
  output logic tx_poll,
  output logic tdmd_clr,
  output logic idon_evt,
  output logic loop_active
);
  seq_st_t st, nxt;
  logic inited;
  logic pause_load, pause_run, pause_exp;

  always_comb begin
    nxt = st;
    if (stop) nxt = SQ_STOP;
    else begin
      case (st)
        SQ_STOP:   nxt = SQ_SWITCH;
        SQ_SWITCH: if (init && !inited) nxt = SQ_RCLR;
                   else if (strt)       nxt = SQ_RXCHK;
        SQ_RCLR:   nxt = SQ_IBWAIT;
        SQ_IBWAIT: if (ib_done) nxt = SQ_SWITCH;
        SQ_RXCHK:  nxt = rx_en ? SQ_RXWAIT : SQ_TXCHK;
        SQ_RXWAIT: if (rx_done) nxt = SQ_TXCHK;
        SQ_TXCHK:  nxt = tx_en ? SQ_TXWAIT : (tdmd ? SQ_RXCHK : SQ_PAUSE);
        SQ_TXWAIT: if (tx_done) nxt = (tx_sent || tdmd) ? SQ_RXCHK : SQ_PAUSE;
        SQ_PAUSE:  if (pause_exp) nxt = SQ_RXCHK;
        default:   nxt = SQ_STOP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= SQ_STOP;
      inited <= 1'b0;
    end else begin
      st <= nxt;
      if (st == SQ_STOP) inited <= 1'b0;
      else if (idon_evt) inited <= 1'b1;
    end
  end

  assign ring_reset  = !stop && (st == SQ_RCLR);
  assign ib_req      = !stop && (st == SQ_IBWAIT);
  assign idon_evt    = ib_req && ib_done;
  assign rx_poll     = !stop && (st == SQ_RXCHK) && rx_en;
  assign tx_poll     = !stop && (st == SQ_TXCHK) && tx_en;
  assign tdmd_clr    = !stop && tdmd &&
                       (((st == SQ_TXCHK) && !tx_en) || ((st == SQ_TXWAIT) && tx_done));
  assign loop_active = (st == SQ_RXCHK) || (st == SQ_RXWAIT) || (st == SQ_TXCHK) ||
                       (st == SQ_TXWAIT) || (st == SQ_PAUSE);
  assign pause_load  = (nxt == SQ_PAUSE) && (st != SQ_PAUSE);
  assign pause_run   = (st == SQ_PAUSE);

  nctl_pause #(.CYC(PAUSE_CYC)) u_pause (
    .clk(clk), .rst_n(rst_n), .load(pause_load), .run(pause_run), .expire(pause_exp)
  );

  p_clr_init_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ring_reset |-> init);
  p_ibreq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ib_req |-> (init && !stop));
  p_poll_strt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_poll || tx_poll) |-> strt);
  p_one_poll_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_poll && tx_poll));
  p_pause_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_PAUSE && !pause_exp && !stop) |=> (st == SQ_PAUSE));
endmodule

// File: rtl/nic_run_ctrl.sv
module nic_run_ctrl
  import nctl_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CLK_HZ = 50_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [1:0]        host_sel,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       csr_q,
  output logic [ADDR_W-1:0] ib_addr,
  output logic              ring_reset,
  output logic              ib_req,
  input  logic              ib_done,
  output logic              rx_poll,
  input  logic              rx_poll_done,
  output logic              tx_poll,
  input  logic              tx_poll_done,
  input  logic              tx_sent,
  output logic              loop_active,
  input  logic              rint_evt,
  input  logic              tint_evt,
  input  logic              miss_evt,
  input  logic              err_evt,
  output logic              irq
);
  localparam int PAUSE_CYC = pause_cycles(CLK_HZ);

  logic stop_w, init_w, strt_w, tdmd_w, ie_w, rxen_w, txen_w;
  logic tdmd_clr_w, idon_w;

  nctl_csr #(.ADDR_W(ADDR_W)) u_csr (
    .clk(clk), .rst_n(rst_n), .wr(host_wr), .sel(host_sel), .wdata(host_wdata),
    .idon_evt(idon_w), .rint_evt(rint_evt), .tint_evt(tint_evt),
    .miss_evt(miss_evt), .err_evt(err_evt), .tdmd_clr(tdmd_clr_w),
    .stop_q(stop_w), .init_q(init_w), .strt_q(strt_w), .tdmd_q(tdmd_w),
    .ie_q(ie_w), .rxen_q(rxen_w), .txen_q(txen_w),
    .csr_q(csr_q), .ib_addr(ib_addr), .irq(irq)
  );

  nctl_seq #(.PAUSE_CYC(PAUSE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .stop(stop_w), .init(init_w), .strt(strt_w),
    .tdmd(tdmd_w), .rx_en(rxen_w), .tx_en(txen_w), .ib_done(ib_done),
    .rx_done(rx_poll_done), .tx_done(tx_poll_done), .tx_sent(tx_sent),
    .ring_reset(ring_reset), .ib_req(ib_req), .rx_poll(rx_poll), .tx_poll(tx_poll),
    .tdmd_clr(tdmd_clr_w), .idon_evt(idon_w), .loop_active(loop_active)
  );

  p_stop_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_w |-> !(rx_poll || tx_poll || ib_req || ring_reset));
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_w |-> !irq);
endmodule

// File: tb/nic_run_ctrl_bench.sv
module nic_run_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;
  localparam int CLK_HZ = 12500;
  localparam int P = CLK_HZ / 625;
  localparam logic [15:0] M_IE = 16'h0010, M_RX = 16'h0020, M_TX = 16'h0040;

  logic clk = 0, rst_n = 0;
  logic host_wr = 0; logic [1:0] host_sel = 0; logic [15:0] host_wdata = 0;
  logic [15:0] csr_q; logic [ADDR_W-1:0] ib_addr;
  logic ring_reset, ib_req, rx_poll, tx_poll, loop_active, irq;
  logic ib_done = 0, rx_poll_done = 0, tx_poll_done = 0, tx_sent = 0;
  logic rint_evt = 0, tint_evt = 0, miss_evt = 0, err_evt = 0;
  logic rx_pend = 0, tx_pend = 0;

  int total = 0, bad = 0;
  int cyc = 0, ntx = 0, nrx = 0, nring = 0, nib = 0;
  int last_tx = 0, last_gap = 0, min_gap = 0, last_rx = 0, rx_gap = 0;
  logic ib_req_d = 0;
  logic [15:0] cfg;

  always #(CLK_PERIOD/2) clk = ~clk;

  nic_run_ctrl #(.ADDR_W(ADDR_W), .CLK_HZ(CLK_HZ)) u_nic_run_ctrl (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .csr_q(csr_q), .ib_addr(ib_addr),
    .ring_reset(ring_reset), .ib_req(ib_req), .ib_done(ib_done),
    .rx_poll(rx_poll), .rx_poll_done(rx_poll_done), .tx_poll(tx_poll),
    .tx_poll_done(tx_poll_done), .tx_sent(tx_sent), .loop_active(loop_active),
    .rint_evt(rint_evt), .tint_evt(tint_evt), .miss_evt(miss_evt),
    .err_evt(err_evt), .irq(irq)
  );

  // poll responders: complete one cycle after the strobe
  always @(negedge clk) begin
    rx_poll_done <= rx_pend; rx_pend <= rx_poll;
    tx_poll_done <= tx_pend; tx_pend <= tx_poll;
  end

  // observers
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (tx_poll) begin
      last_gap = cyc - last_tx; last_tx = cyc; ntx = ntx + 1;
      if (last_gap < min_gap) min_gap = last_gap;
    end
    if (rx_poll) begin rx_gap = cyc - last_rx; last_rx = cyc; nrx = nrx + 1; end
    if (ring_reset) nring = nring + 1;
    if (ib_req && !ib_req_d) nib = nib + 1;
    ib_req_d = ib_req;
  end

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    tick(); host_wr = 1; host_sel = s; host_wdata = d;
    tick(); host_wr = 0;
  endtask

  task automatic pulse_ib(); tick(); ib_done = 1; tick(); ib_done = 0; endtask

  task automatic measure(output int g);
    int n0 = ntx;
    while (ntx < n0 + 3) tick();
    g = last_gap;
  endtask

  initial begin
    int g, r0, n0, x0;
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=0", 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int g, r0, n0, x0;
    repeat (5) tick();
    rst_n = 1; tick();
    // R1 reset state
    chk(csr_q == 16'h0001, "R1 csr", csr_q, 16'h0001);
    chk(!irq && !ib_req && !ring_reset && !rx_poll && !tx_poll, "R1 outputs",
        {irq, ib_req, ring_reset, rx_poll, tx_poll}, 0);
    // R3 address while halted
    wr(2'd1, 16'hBEEF); wr(2'd2, 16'h005A);
    chk(ib_addr == 24'h5ABEEF, "R3 load", ib_addr, 24'h5ABEEF);
    // R2 init write clears halt; R4 init sequence
    cfg = 16'h0000;
    wr(2'd0, cfg | 16'h0002);
    chk(csr_q[2:0] == 3'b010, "R2 init", csr_q[2:0], 3'b010);
    repeat (3) tick();
    chk(nring == 1 && ib_req, "R4 ring reset then fetch", nring, 1);
    wr(2'd1, 16'h1111);
    chk(ib_addr == 24'h5ABEEF, "R3 ignored when running", ib_addr, 24'h5ABEEF);
    repeat (10) tick();
    chk(nrx + ntx == 0 && ib_req, "R4 no poll before fetch done", nrx + ntx, 0);
    pulse_ib();
    chk(!ib_req && csr_q[8], "R9 init-done flag", csr_q[8], 1);
    chk(!irq && csr_q[15], "R10 gated off", {irq, csr_q[15]}, 2'b01);
    cfg = M_IE; wr(2'd0, cfg);
    chk(irq, "R10 enabled", irq, 1);
    wr(2'd0, cfg | 16'h0100);
    chk(!csr_q[8] && !irq && !csr_q[15], "R8 w1c init-done", csr_q[8], 0);
    repeat (20) tick();
    chk(nrx + ntx == 0 && !loop_active, "R4 idle without start", nrx + ntx, 0);
    // start: R5 and R6 order
    cfg = M_IE | M_RX | M_TX; tx_sent = 0;
    wr(2'd0, cfg | 16'h0004);
    while (nrx + ntx == 0) tick();
    chk(nrx == 1 && ntx == 0, "R6 receive first", nrx, 1);
    chk(nring == 1 && nib == 1, "R5 start keeps rings", nring, 1);
    // R7/R6 sweep of poll spacing
    for (int rx = 0; rx < 2; rx++) begin
      for (int s = 0; s < 2; s++) begin
        cfg = M_IE | M_TX | (rx ? M_RX : 16'h0);
        tx_sent = s[0];
        wr(2'd0, cfg);
        measure(g);
        chk(g == 3 + rx + (s ? 0 : P), "R7 spacing", g, 3 + rx + (s ? 0 : P));
      end
    end
    // R7 demand skips one pause and clears
    cfg = M_IE | M_TX; tx_sent = 0; wr(2'd0, cfg); measure(g);
    min_gap = 1000; n0 = ntx;
    wr(2'd0, cfg | 16'h0008);
    while (ntx < n0 + 3) tick();
    chk(min_gap == 3, "R7 demand skip", min_gap, 3);
    chk(!csr_q[3], "R7 demand cleared", csr_q[3], 0);
    measure(g);
    chk(g == 3 + P, "R7 pause back", g, 3 + P);
    // R6 receive only
    cfg = M_IE | M_RX; wr(2'd0, cfg);
    repeat (P + 10) tick();
    x0 = ntx; r0 = nrx;
    while (nrx < r0 + 2) tick();
    chk(ntx == x0 && rx_gap == 3 + P, "R6 tx disabled", rx_gap, 3 + P);
    // R8 flags
    tick(); rint_evt = 1; tint_evt = 1; miss_evt = 1; err_evt = 1;
    tick(); rint_evt = 0; tint_evt = 0; miss_evt = 0; err_evt = 0;
    chk(csr_q[12:9] == 4'hF && irq, "R8 set", csr_q[12:9], 4'hF);
    wr(2'd0, cfg);
    chk(csr_q[12:9] == 4'hF, "R8 zeros no effect", csr_q[12:9], 4'hF);
    wr(2'd0, cfg | 16'h1400);
    chk(csr_q[12:9] == 4'b0101, "R8 selective clear", csr_q[12:9], 4'b0101);
    tick(); host_wr = 1; host_sel = 0; host_wdata = cfg | 16'h0400; tint_evt = 1;
    tick(); host_wr = 0; tint_evt = 0;
    chk(csr_q[10], "R8 event wins", csr_q[10], 1);
    wr(2'd0, cfg | 16'h1F00);
    chk(csr_q[12:8] == 0 && !irq, "R10 all clear", csr_q[12:8], 0);
    // R11/R2 halt
    cfg = M_IE | M_RX | M_TX; wr(2'd0, cfg);
    while (!tx_poll) tick();
    wr(2'd0, cfg | 16'h0001);
    chk(csr_q[2:0] == 3'b001, "R2 halt clears init/start", csr_q[2:0], 3'b001);
    chk(!rx_poll && !tx_poll && !ib_req, "R11 quiet", {rx_poll, tx_poll}, 0);
    r0 = nrx; x0 = ntx; repeat (40) tick();
    chk(nrx == r0 && ntx == x0 && !loop_active, "R11 loop abandoned", nrx + ntx, r0 + x0);
    // R5 restart with start only
    wr(2'd0, cfg | 16'h0004);
    repeat (40) tick();
    chk(nring == 1 && nib == 1 && ntx > x0, "R5 restart keeps rings", nring, 1);
    // R2 halt wins over init in same write
    wr(2'd0, cfg | 16'h0003);
    chk(csr_q[2:0] == 3'b001, "R2 halt wins", csr_q[2:0], 3'b001);
    // R4 init and start together
    r0 = nrx; x0 = ntx;
    wr(2'd0, cfg | 16'h0006);
    repeat (12) tick();
    chk(nring == 2 && ib_req && nrx == r0 && ntx == x0, "R4 init before loop", nring, 2);
    pulse_ib();
    repeat (6) tick();
    chk(nrx > r0 && loop_active, "R4 loop after fetch", nrx - r0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule